// File: doc/BRIEF.md
# Infrared Mode Select and Loopback Controller

This block holds the one control/status register that decides which of three infrared codec engines owns the shared infrared transceiver pins. The three engines are slow-rate (SIR), medium-rate (MIR) and fast-rate (FIR). The block decodes a two-bit select field into per-engine enables. It carries serial data between the chosen engine and the external transmit and receive pins. It can also loop the chosen engine's transmit shifter output straight back into that engine's receive shifter for self-test.

The medium-rate and fast-rate transmitters each report frame start and frame end. From these the block keeps two read-only "safe to disable" flags. Software polls a flag before it changes mode, so a frame is never cut off. Transmit and receive paths are steered independently, and both may carry data at the same time.

Top module: `ir_mode_ctrl`

## Requirements
- R1: While reset is applied and straight after it, the register reads 0x18 (both done flags set, every other bit 0), all engine enables are low and the transmit pin sits at its idle level.
- R2: Select field bits [1:0] drive the enables `eng_en_o` (bit 0 SIR, bit 1 MIR, bit 2 FIR). Code 00 enables none, 01 enables SIR, 10 enables MIR and 11 enables FIR. A write takes effect on the clock edge that samples it.
- R3: At no time is more than one engine enable high.
- R4: With loopback bit [2] clear, the transmit pin follows the selected engine's transmit data. The selected engine's receive input follows the receive pin combinationally. Both paths work at the same time.
- R5: With loopback bit [2] set and an engine selected, that engine's receive input follows its own transmit data. The transmit pin stays at its idle level, and the receive pin has no effect.
- R6: Each unselected engine sees its receive input held at the receive idle level. With no engine selected, the transmit pin is idle.
- R7: While its engine is selected, a done flag (bit 3 MIR, bit 4 FIR) clears on the edge that samples that transmitter's frame-start pulse. It sets again on the edge that samples the frame-end pulse. Start wins when both pulses come together.
- R8: A done flag reads 1 while its engine is not selected, and it stays 1 right after that engine is selected until a frame starts.
- R9: Bits [2:0] read back the select and loopback values from the most recent write.
- R10: Writes to bits [7:3] have no effect on any output or on the read value. Bits [7:5] always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | REG_W | Register write data |
| reg_rdata_o | output | REG_W | Register read value |
| eng_en_o | output | 3 | Engine enables (0 SIR, 1 MIR, 2 FIR) |
| eng_tx_i | input | 3 | Serial transmit data from each engine |
| eng_rx_o | output | 3 | Serial receive data to each engine |
| pin_tx_o | output | 1 | External transmit pin |
| pin_rx_i | input | 1 | External receive pin |
| tx_start_i | input | 2 | Frame-start pulse (0 MIR, 1 FIR) |
| tx_end_i | input | 2 | Frame-end pulse (0 MIR, 1 FIR) |

## Verification
The bench builds the block with REG_W = 8, a transmit idle level of 0 and a receive idle level of 1. Because the two idle levels differ, a parked receive input can be told apart from a forwarded pin value or a looped-back transmit value, so a swap between those sources shows up at the ports. With the 8-bit width, random writes reach every code of the reserved and read-only bits. Random frame pulses reach the case where start and end arrive in the same cycle, and the case where an engine is switched away and back in the middle of a frame.

// File: rtl/ir_mode_pkg.sv
package ir_mode_pkg;
  localparam int N_ENG   = 3;
  localparam int ENG_SIR = 0;
  localparam int ENG_MIR = 1;
  localparam int ENG_FIR = 2;
  localparam int N_DONE  = 2;

  localparam int B_LBM   = 2;
  localparam int B_MDONE = 3;
  localparam int B_FDONE = 4;
  localparam int B_RSVD  = 5;

  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_SIR  = 2'b01,
    SEL_MIR  = 2'b10,
    SEL_FIR  = 2'b11
  } ir_sel_e;
endpackage

// File: rtl/ir_mode_reg.sv
module ir_mode_reg
  import ir_mode_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       sel_wr_i,
  input  logic             lbm_wr_i,
  output ir_sel_e          sel_o,
  output logic             lbm_o,
  output logic [N_ENG-1:0] en_o
);
  ir_sel_e sel_q;
  logic    lbm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= SEL_NONE;
      lbm_q <= 1'b0;
    end else if (we_i) begin
      sel_q <= ir_sel_e'(sel_wr_i);
      lbm_q <= lbm_wr_i;
    end
  end

  always_comb begin
    en_o = '0;
    unique case (sel_q)
      SEL_SIR:  en_o[ENG_SIR] = 1'b1;
      SEL_MIR:  en_o[ENG_MIR] = 1'b1;
      SEL_FIR:  en_o[ENG_FIR] = 1'b1;
      default:  en_o = '0;
    endcase
  end

  assign sel_o = sel_q;
  assign lbm_o = lbm_q;
endmodule

// File: rtl/ir_done_flag.sv
module ir_done_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic start_i,
  input  logic end_i,
  output logic done_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b1;
    else if (!en_i)   flag_q <= 1'b1;
    else if (start_i) flag_q <= 1'b0;  // new frame outranks end
    else if (end_i)   flag_q <= 1'b1;
  end

  assign done_o = flag_q | ~en_i;

  AST_DONE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && start_i) |=> !flag_q); // R7
  AST_DONE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && end_i && !start_i) |=> flag_q); // R7
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> flag_q); // R8
endmodule

// File: rtl/ir_path_mux.sv
module ir_path_mux
  import ir_mode_pkg::*;
#(
  parameter logic TX_IDLE = 1'b0,
  parameter logic RX_IDLE = 1'b1
) (
  input  logic [N_ENG-1:0] en_i,
  input  logic             lbm_i,
  input  logic [N_ENG-1:0] eng_tx_i,
  input  logic             pin_rx_i,
  output logic [N_ENG-1:0] eng_rx_o,
  output logic             pin_tx_o
);
  logic any_en;
  assign any_en = |en_i;

  for (genvar g = 0; g < N_ENG; g++) begin : g_rx
    always_comb begin
      if (!en_i[g])  eng_rx_o[g] = RX_IDLE;
      else if (lbm_i) eng_rx_o[g] = eng_tx_i[g];
      else            eng_rx_o[g] = pin_rx_i;
    end
  end

  always_comb begin
    if (lbm_i || !any_en) pin_tx_o = TX_IDLE;
    else                  pin_tx_o = |(en_i & eng_tx_i);
  end
endmodule

// File: rtl/ir_mode_ctrl.sv
module ir_mode_ctrl
  import ir_mode_pkg::*;
#(
  parameter int   REG_W   = 8,
  parameter logic TX_IDLE = 1'b0,
  parameter logic RX_IDLE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic [2:0]       eng_en_o,
  input  logic [2:0]       eng_tx_i,
  output logic [2:0]       eng_rx_o,
  output logic             pin_tx_o,
  input  logic             pin_rx_i,
  input  logic [1:0]       tx_start_i,
  input  logic [1:0]       tx_end_i
);
  localparam int RSVD_W = REG_W - B_RSVD;

  ir_sel_e          sel;
  logic             lbm;
  logic [N_ENG-1:0] en;
  logic [N_DONE-1:0] done;
  logic [N_DONE-1:0] done_en;
  logic             unused_wbits;

  assign unused_wbits = ^reg_wdata_i[REG_W-1:B_MDONE];

  ir_mode_reg i_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .sel_wr_i (reg_wdata_i[1:0]),
    .lbm_wr_i (reg_wdata_i[B_LBM]),
    .sel_o    (sel),
    .lbm_o    (lbm),
    .en_o     (en)
  );

  assign done_en = {en[ENG_FIR], en[ENG_MIR]};

  for (genvar g = 0; g < N_DONE; g++) begin : g_done
    ir_done_flag i_flag (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (done_en[g]),
      .start_i (tx_start_i[g]),
      .end_i   (tx_end_i[g]),
      .done_o  (done[g])
    );
  end

  ir_path_mux #(.TX_IDLE(TX_IDLE), .RX_IDLE(RX_IDLE)) i_mux (
    .en_i     (en),
    .lbm_i    (lbm),
    .eng_tx_i (eng_tx_i),
    .pin_rx_i (pin_rx_i),
    .eng_rx_o (eng_rx_o),
    .pin_tx_o (pin_tx_o)
  );

  always_comb begin
    reg_rdata_o          = '0;
    reg_rdata_o[1:0]     = sel;
    reg_rdata_o[B_LBM]   = lbm;
    reg_rdata_o[B_MDONE] = done[0];
    reg_rdata_o[B_FDONE] = done[1];
  end

  assign eng_en_o = en;

  AST_ONE_ENGINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(eng_en_o)); // R3
  AST_WR_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> (reg_rdata_o[2:0] == $past(reg_wdata_i[2:0]))); // R9
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[REG_W-1:B_RSVD] == RSVD_W'(0)); // R10
  AST_LOOP_PIN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[B_LBM] |-> (pin_tx_o == TX_IDLE)); // R5
  AST_OFF_PIN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_en_o == 3'b000) |-> (pin_tx_o == TX_IDLE)); // R6
endmodule

// File: tb/test_ir_mode_ctrl.sv
module test_ir_mode_ctrl;
  localparam int   REG_W   = 8;
  localparam logic TX_IDLE = 1'b0;
  localparam logic RX_IDLE = 1'b1;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             reg_we_i = 1'b0;
  logic [REG_W-1:0] reg_wdata_i = '0;
  logic [REG_W-1:0] reg_rdata_o;
  logic [2:0]       eng_en_o;
  logic [2:0]       eng_tx_i = '0;
  logic [2:0]       eng_rx_o;
  logic             pin_tx_o;
  logic             pin_rx_i = 1'b0;
  logic [1:0]       tx_start_i = '0;
  logic [1:0]       tx_end_i = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [1:0] m_sel = 2'b00;
  logic       m_lbm = 1'b0;
  logic [1:0] m_flag = 2'b11;

  always #2 clk_i = ~clk_i;

  ir_mode_ctrl #(.REG_W(REG_W), .TX_IDLE(TX_IDLE), .RX_IDLE(RX_IDLE)) i_ir_mode_ctrl (
    .clk_i, .rst_ni, .reg_we_i, .reg_wdata_i, .reg_rdata_o, .eng_en_o,
    .eng_tx_i, .eng_rx_o, .pin_tx_o, .pin_rx_i, .tx_start_i, .tx_end_i
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] exp_en(input logic [1:0] s);
    case (s)
      2'b01: return 3'b001;
      2'b10: return 3'b010;
      2'b11: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [1:0] exp_denable(input logic [1:0] s);
    return {s == 2'b11, s == 2'b10};
  endfunction

  // apply last cycle's inputs to the model, as the clock edge did
  task automatic model_edge();
    logic [1:0] de;
    de = exp_denable(m_sel);
    for (int k = 0; k < 2; k++) begin
      if (!de[k])             m_flag[k] = 1'b1;
      else if (tx_start_i[k]) m_flag[k] = 1'b0;
      else if (tx_end_i[k])   m_flag[k] = 1'b1;
    end
    if (reg_we_i) begin
      m_sel = reg_wdata_i[1:0];
      m_lbm = reg_wdata_i[2];
    end
  endtask

  task automatic check_all();
    logic [2:0] en;
    logic [1:0] dn;
    logic [2:0] rx;
    logic       tx;
    en = exp_en(m_sel);
    dn = m_flag | ~exp_denable(m_sel);
    for (int k = 0; k < 3; k++)
      rx[k] = !en[k] ? RX_IDLE : (m_lbm ? eng_tx_i[k] : pin_rx_i);
    tx = (m_lbm || en == 3'b000) ? TX_IDLE : |(en & eng_tx_i);
    check("R2 enables", {5'b0, eng_en_o}, {5'b0, en});
    check("R3 onehot", {7'b0, $countones(eng_en_o) <= 1}, 8'd1);
    check("R4/R5/R6 engine rx", {5'b0, eng_rx_o}, {5'b0, rx});
    check("R4/R5/R6 pin tx", {7'b0, pin_tx_o}, {7'b0, tx});
    check("R9 fields", {5'b0, reg_rdata_o[2:0]}, {5'b0, m_lbm, m_sel});
    check("R7/R8 done", {6'b0, reg_rdata_o[4:3]}, {6'b0, dn});
    check("R10 reserved", {5'b0, reg_rdata_o[7:5]}, 8'd0);
  endtask

  // one cycle: settle model, check, then drive next inputs
  task automatic step(input bit we, input logic [7:0] wd, input logic [2:0] tx,
                      input logic prx, input logic [1:0] st, input logic [1:0] en);
    @(negedge clk_i);
    model_edge();
    check_all();
    reg_we_i = we; reg_wdata_i = wd; eng_tx_i = tx;
    pin_rx_i = prx; tx_start_i = st; tx_end_i = en;
  endtask

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    // R1 during reset
    repeat (3) @(negedge clk_i);
    check("R1 reset rdata", reg_rdata_o, 8'h18);
    check("R1 reset enables", {5'b0, eng_en_o}, 8'd0);
    check("R1 reset pin tx", {7'b0, pin_tx_o}, {7'b0, TX_IDLE});
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after reset rdata", reg_rdata_o, 8'h18);

    // directed: each select code, normal path (R2, R4)
    step(1, 8'h01, 3'b000, 1, 0, 0);
    step(0, 8'h00, 3'b001, 0, 0, 0);
    step(1, 8'h02, 3'b010, 1, 0, 0);
    step(0, 8'h00, 3'b010, 0, 0, 0);
    // R8: MIR selected, flag stays set until start; R7 start then end
    step(0, 8'h00, 3'b000, 0, 2'b01, 0);
    step(0, 8'h00, 3'b000, 0, 0, 2'b01);
    step(0, 8'h00, 3'b000, 0, 0, 0);
    // R10: all-ones write -> FIR with loopback, upper bits ignored
    step(1, 8'hFF, 3'b100, 1, 0, 0);
    // R5: loopback, pin rx toggles without effect
    step(0, 8'h00, 3'b100, 0, 0, 0);
    step(0, 8'h00, 3'b000, 1, 0, 0);
    // R7: start and end together -> start wins
    step(0, 8'h00, 3'b100, 1, 2'b10, 2'b10);
    step(0, 8'h00, 3'b000, 0, 0, 0);
    // R8: deselect mid-frame -> flag reads 1, reselect keeps it 1
    step(1, 8'h00, 3'b000, 0, 0, 0);
    step(1, 8'h03, 3'b000, 0, 0, 0);
    step(0, 8'h00, 3'b000, 0, 0, 0);
    // R10: write with only upper bits set
    step(1, 8'hF8, 3'b111, 1, 0, 0);
    step(0, 8'h00, 3'b111, 0, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      bit we;
      we = ($urandom_range(0, 5) == 0);
      step(we, 8'($urandom()), 3'($urandom()), 1'($urandom()),
           ($urandom_range(0, 7) == 0) ? 2'($urandom()) : 2'b00,
           ($urandom_range(0, 5) == 0) ? 2'($urandom()) : 2'b00);
    end
    @(negedge clk_i);
    model_edge();
    check_all();

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule